// File: doc/BRIEF.md
# BT.656 Byte-Serial Video Stream Formatter

This block turns a stream of 4:2:2 pixel pairs into a byte-serial BT.656 video stream. It emits one 8-bit byte per clock, so at a 27 MHz clock it delivers the standard 27 Mbyte/s rate. It keeps its own horizontal byte counter and line counter for 525-line or 625-line operation. It inserts the end-of-active and start-of-active timing codes and fills every blanking interval with neutral black. During active video it pulls one pixel pair from an upstream source through a ready/valid handshake.

Each pair carries two luma samples and one Cb/Cr chroma pair. It is serialised as Cb, first Y, Cr, second Y. The four-byte timing codes carry the field, vertical-blanking and horizontal flags, protected by Hamming bits, so a downstream receiver can lock to the raster from the stream alone. The line width is set by parameters; the line numbers at which blanking and field changes occur are fixed per standard. The standard is chosen by an input that is sampled only at frame boundaries.

Top module: `bt656_formatter`

## Requirements
- R1: While rst_n is low, vid_strobe, vid_data, pix_ready and pix_underrun are all 0.
- R2: From the first clock edge after reset is released, vid_strobe is 1 on every cycle. Each line is LINE_BYTES_525 bytes long (default 1716) in 525-line mode and LINE_BYTES_625 bytes long (default 1728) in 625-line mode. Lines are numbered from 1, and the first line after reset is line 1.
- R3: Each line begins with an end-of-active code at byte offsets 0..3. The start-of-active code occupies the four bytes just before the last ACTIVE_BYTES bytes (default 1440) of the line. Both codes are the bytes FF, 00, 00, then a flag word.
- R4: The flag word is, from bit 7 down: 1, F, V, H, V^H, F^H, F^V, F^V^H. H is 1 in the end-of-active code and 0 in the start-of-active code.
- R5: In 625-line mode, V is 1 on lines 624..625 and 1..22, and on lines 311..335; it is 0 on all other lines.
- R6: In 525-line mode, V is 1 on lines 1..9 and 264..272; it is 0 on all other lines.
- R7: In 625-line mode, F is 0 on lines 1..312 and 1 on lines 313..625. In 525-line mode, F is 1 on lines 1..3 and 266..525, and 0 on lines 4..265.
- R8: On lines with V=0, the active region carries pixel pairs as Cb, Y0, Cr, Y1, repeating. pix_ready is high in the cycle before each Cb byte appears, and a pair is taken when pix_ready and pix_valid are both high.
- R9: Every byte between the two codes, and the whole active region of lines with V=1, is 0x80 at even byte offsets from the line start and 0x10 at odd offsets.
- R10: In the active region, a pixel byte of 0x00 is sent as 0x01 and a byte of 0xFF is sent as 0xFE. Outside the codes, no 0x00 or 0xFF byte is ever emitted.
- R11: If pix_valid is low while pix_ready is high, the previously taken pair is sent again and pix_underrun is 1 in the same cycle as that pair's Cb byte. Before any pair has been taken, the repeated pair is black (Y=0x10, Cb=Cr=0x80).
- R12: pal_mode (1 = 625-line, 0 = 525-line) is sampled on the first cycle after reset and at the last byte of each frame. A change at any other time first takes effect on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_mode | input | 1 | Standard select: 1 for 625-line, 0 for 525-line |
| pix_valid | input | 1 | Upstream pixel pair available |
| pix_cb | input | 8 | Blue-difference chroma of the pair |
| pix_y0 | input | 8 | First luma sample of the pair |
| pix_cr | input | 8 | Red-difference chroma of the pair |
| pix_y1 | input | 8 | Second luma sample of the pair |
| pix_ready | output | 1 | Pair is consumed at this edge when valid |
| vid_data | output | 8 | Serial BT.656 byte |
| vid_strobe | output | 1 | Byte strobe, high once streaming |
| pix_underrun | output | 1 | Pulse marking a repeated pair, aligned with its Cb byte |

## Verification
The bench shrinks the line to 8 active bytes and runs complete frames in both standards, so every line number at which V or F changes is crossed. It predicts every byte, which catches a blanking window shifted by one line, a swapped protection bit or a wrong H polarity in the flag words. Upstream data is throttled, and upstream bytes include 0x00 and 0xFF. This exposes a design that emits a stray timing-like byte, loses the Cb/Y/Cr/Y phase, or fails to flag and repeat a missed pair. The standard select is toggled in the middle of a frame, so a design that switches line length before the frame ends breaks the predicted byte sequence.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

    localparam int unsigned LINE_W = 10;

    typedef enum logic [1:0] {
        RG_EAV   = 2'd0,
        RG_HFILL = 2'd1,
        RG_SAV   = 2'd2,
        RG_ACT   = 2'd3
    } region_e;

    typedef struct packed {
        logic [7:0] cb;
        logic [7:0] y0;
        logic [7:0] cr;
        logic [7:0] y1;
    } pair_t;

    localparam logic [7:0] CODE_LEAD = 8'hFF;
    localparam logic [7:0] CODE_ZERO = 8'h00;
    localparam logic [7:0] FILL_CHR  = 8'h80;
    localparam logic [7:0] FILL_LUM  = 8'h10;

    localparam logic [LINE_W-1:0] LINES_525 = 10'd525;
    localparam logic [LINE_W-1:0] LINES_625 = 10'd625;

    // 625-line blanking and field boundaries
    localparam logic [LINE_W-1:0] P_VON_A  = 10'd624;
    localparam logic [LINE_W-1:0] P_VOFF_A = 10'd23;
    localparam logic [LINE_W-1:0] P_VON_B  = 10'd311;
    localparam logic [LINE_W-1:0] P_VOFF_B = 10'd336;
    localparam logic [LINE_W-1:0] P_FLD_B  = 10'd313;

    // 525-line blanking and field boundaries
    localparam logic [LINE_W-1:0] N_VOFF_A = 10'd10;
    localparam logic [LINE_W-1:0] N_VON_B  = 10'd264;
    localparam logic [LINE_W-1:0] N_VOFF_B = 10'd273;
    localparam logic [LINE_W-1:0] N_FLD_A  = 10'd4;
    localparam logic [LINE_W-1:0] N_FLD_B  = 10'd266;

    function automatic logic [7:0] flag_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] keep_legal(input logic [7:0] b);
        if (b == 8'h00) return 8'h01;
        if (b == 8'hFF) return 8'hFE;
        return b;
    endfunction

endpackage

// File: rtl/bt656_raster.sv
module bt656_raster
    import bt656_pkg::*;
#(
    parameter int unsigned ACTIVE_BYTES   = 1440,
    parameter int unsigned LINE_BYTES_525 = 1716,
    parameter int unsigned LINE_BYTES_625 = 1728
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pal_mode,
    output region_e           region_o,
    output logic [1:0]        sub_o,
    output logic              fill_luma_o,
    output logic [LINE_W-1:0] line_o,
    output logic              mode_o
);

    localparam int unsigned LMAX = (LINE_BYTES_625 > LINE_BYTES_525) ? LINE_BYTES_625 : LINE_BYTES_525;
    localparam int unsigned H_W  = $clog2(LMAX);

    localparam logic [H_W-1:0] LAST_N = H_W'(LINE_BYTES_525 - 1);
    localparam logic [H_W-1:0] LAST_P = H_W'(LINE_BYTES_625 - 1);
    localparam logic [H_W-1:0] ACT_N  = H_W'(LINE_BYTES_525 - ACTIVE_BYTES);
    localparam logic [H_W-1:0] ACT_P  = H_W'(LINE_BYTES_625 - ACTIVE_BYTES);
    localparam logic [H_W-1:0] SAV_N  = H_W'(LINE_BYTES_525 - ACTIVE_BYTES - 4);
    localparam logic [H_W-1:0] SAV_P  = H_W'(LINE_BYTES_625 - ACTIVE_BYTES - 4);
    localparam logic [H_W-1:0] EAV_LEN = H_W'(4);
    localparam logic [LINE_W-1:0] FIRST_LINE = LINE_W'(1);

    typedef struct packed {
        logic [H_W-1:0]    h;
        logic [LINE_W-1:0] line;
        logic              mode;
        logic              run;
    } rast_t;

    rast_t st_q, st_d;

    logic              mode_eff;
    logic [H_W-1:0]    h_last, act_start, sav_start;
    logic [LINE_W-1:0] n_lines;
    logic              end_line, end_frame;

    always_comb begin
        mode_eff  = st_q.run ? st_q.mode : pal_mode;
        h_last    = mode_eff ? LAST_P : LAST_N;
        act_start = mode_eff ? ACT_P  : ACT_N;
        sav_start = mode_eff ? SAV_P  : SAV_N;
        n_lines   = mode_eff ? LINES_625 : LINES_525;
        end_line  = (st_q.h == h_last);
        end_frame = end_line && (st_q.line == n_lines);

        st_d     = st_q;
        st_d.run = 1'b1;
        if (!st_q.run) begin
            st_d.mode = pal_mode;
        end
        if (end_line) begin
            st_d.h    = '0;
            st_d.line = end_frame ? FIRST_LINE : st_q.line + FIRST_LINE;
        end else begin
            st_d.h = st_q.h + H_W'(1);
        end
        if (end_frame) begin
            st_d.mode = pal_mode;
        end

        if (st_q.h < EAV_LEN) begin
            region_o = RG_EAV;
        end else if (st_q.h < sav_start) begin
            region_o = RG_HFILL;
        end else if (st_q.h < act_start) begin
            region_o = RG_SAV;
        end else begin
            region_o = RG_ACT;
        end
    end

    assign sub_o       = st_q.h[1:0];
    assign fill_luma_o = st_q.h[0];
    assign line_o      = st_q.line;
    assign mode_o      = mode_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{h: '0, line: FIRST_LINE, mode: 1'b0, run: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.line >= FIRST_LINE) && (st_q.line <= LINES_625));

    // R2
    h_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.h <= LAST_P || st_q.h <= LAST_N);

    // R12
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !end_frame) |=> $stable(st_q.mode));

endmodule

// File: rtl/bt656_field_flags.sv
module bt656_field_flags
    import bt656_pkg::*;
(
    input  logic [LINE_W-1:0] line_i,
    input  logic              mode_i,
    output logic              fld_o,
    output logic              vblk_o
);

    logic p_v, p_f, n_v, n_f;

    always_comb begin
        p_v = (line_i >= P_VON_A) || (line_i < P_VOFF_A) ||
              ((line_i >= P_VON_B) && (line_i < P_VOFF_B));
        p_f = (line_i >= P_FLD_B);
        n_v = (line_i < N_VOFF_A) ||
              ((line_i >= N_VON_B) && (line_i < N_VOFF_B));
        n_f = (line_i < N_FLD_A) || (line_i >= N_FLD_B);
        vblk_o = mode_i ? p_v : n_v;
        fld_o  = mode_i ? p_f : n_f;
    end

endmodule

// File: rtl/bt656_byte_mux.sv
module bt656_byte_mux
    import bt656_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  region_e    region_i,
    input  logic [1:0] sub_i,
    input  logic       fill_luma_i,
    input  logic       fld_i,
    input  logic       vblk_i,
    input  logic       pix_valid,
    input  pair_t      pix_i,
    output logic       pix_ready,
    output logic [7:0] vid_data,
    output logic       vid_strobe,
    output logic       pix_underrun
);

    localparam pair_t BLACK = '{cb: FILL_CHR, y0: FILL_LUM, cr: FILL_CHR, y1: FILL_LUM};

    typedef struct packed {
        pair_t      pair;
        logic [7:0] data;
        logic       strobe;
        logic       underrun;
        logic       code;
    } mux_t;

    mux_t       st_q, st_d;
    logic [7:0] fill_b;
    logic [7:0] code_b;

    always_comb begin
        pix_ready = (region_i == RG_ACT) && !vblk_i && (sub_i == 2'd0);

        st_d          = st_q;
        st_d.strobe   = 1'b1;
        st_d.underrun = pix_ready && !pix_valid;
        st_d.code     = (region_i == RG_EAV) || (region_i == RG_SAV);
        if (pix_ready && pix_valid) begin
            st_d.pair = pix_i;
        end

        fill_b = fill_luma_i ? FILL_LUM : FILL_CHR;
        case (sub_i)
            2'd0:    code_b = CODE_LEAD;
            2'd3:    code_b = flag_word(fld_i, vblk_i, region_i == RG_EAV);
            default: code_b = CODE_ZERO;
        endcase

        case (region_i)
            RG_EAV, RG_SAV: st_d.data = code_b;
            RG_HFILL:       st_d.data = fill_b;
            default: begin
                if (vblk_i) begin
                    st_d.data = fill_b;
                end else begin
                    case (sub_i)
                        2'd0:    st_d.data = keep_legal(st_d.pair.cb);
                        2'd1:    st_d.data = keep_legal(st_d.pair.y0);
                        2'd2:    st_d.data = keep_legal(st_d.pair.cr);
                        default: st_d.data = keep_legal(st_d.pair.y1);
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pair: BLACK, data: 8'h00, strobe: 1'b0, underrun: 1'b0, code: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign vid_data     = st_q.data;
    assign vid_strobe   = st_q.strobe;
    assign pix_underrun = st_q.underrun;

    // R4
    flag_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.strobe, 3) && $past(st_q.data, 3) == 8'hFF &&
         $past(st_q.data, 2) == 8'h00 && $past(st_q.data, 1) == 8'h00)
        |-> (st_q.data[7] &&
             st_q.data[3] == (st_q.data[5] ^ st_q.data[4]) &&
             st_q.data[2] == (st_q.data[6] ^ st_q.data[4]) &&
             st_q.data[1] == (st_q.data[6] ^ st_q.data[5]) &&
             st_q.data[0] == (st_q.data[6] ^ st_q.data[5] ^ st_q.data[4])));

    // R10
    no_false_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.strobe && !st_q.code) |-> (st_q.data != 8'h00 && st_q.data != 8'hFF));

    // R11
    underrun_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.underrun |=> !st_q.underrun);

    // R2
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |=> st_q.strobe);

endmodule

// File: rtl/bt656_formatter.sv
module bt656_formatter
    import bt656_pkg::*;
#(
    parameter int unsigned ACTIVE_BYTES   = 1440,
    parameter int unsigned LINE_BYTES_525 = 1716,
    parameter int unsigned LINE_BYTES_625 = 1728
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pal_mode,
    input  logic       pix_valid,
    input  logic [7:0] pix_cb,
    input  logic [7:0] pix_y0,
    input  logic [7:0] pix_cr,
    input  logic [7:0] pix_y1,
    output logic       pix_ready,
    output logic [7:0] vid_data,
    output logic       vid_strobe,
    output logic       pix_underrun
);

    region_e           region_w;
    logic [1:0]        sub_w;
    logic              fill_luma_w;
    logic [LINE_W-1:0] line_w;
    logic              mode_w;
    logic              fld_w, vblk_w;
    pair_t             pair_w;

    assign pair_w = '{cb: pix_cb, y0: pix_y0, cr: pix_cr, y1: pix_y1};

    bt656_raster #(
        .ACTIVE_BYTES  (ACTIVE_BYTES),
        .LINE_BYTES_525(LINE_BYTES_525),
        .LINE_BYTES_625(LINE_BYTES_625)
    ) u_raster (
        .clk        (clk),
        .rst_n      (rst_n),
        .pal_mode   (pal_mode),
        .region_o   (region_w),
        .sub_o      (sub_w),
        .fill_luma_o(fill_luma_w),
        .line_o     (line_w),
        .mode_o     (mode_w)
    );

    bt656_field_flags u_flags (
        .line_i(line_w),
        .mode_i(mode_w),
        .fld_o (fld_w),
        .vblk_o(vblk_w)
    );

    bt656_byte_mux u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .region_i    (region_w),
        .sub_i       (sub_w),
        .fill_luma_i (fill_luma_w),
        .fld_i       (fld_w),
        .vblk_i      (vblk_w),
        .pix_valid   (pix_valid),
        .pix_i       (pair_w),
        .pix_ready   (pix_ready),
        .vid_data    (vid_data),
        .vid_strobe  (vid_strobe),
        .pix_underrun(pix_underrun)
    );

endmodule

// File: tb/bt656_formatter_tb.sv
module bt656_formatter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ACT  = 8;
    localparam int LN   = 20;
    localparam int LP   = 24;
    localparam int RUN_BYTES = 36500;

    logic       clk, rst_n, pal_mode, pix_valid;
    logic [7:0] pix_cb, pix_y0, pix_cr, pix_y1;
    logic       pix_ready, vid_strobe, pix_underrun;
    logic [7:0] vid_data;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 0;

    int  bline, bh, dcnt;
    bit  bmode, exp_under;
    logic [7:0] ecb, ey0, ecr, ey1;

    bt656_formatter #(
        .ACTIVE_BYTES  (ACT),
        .LINE_BYTES_525(LN),
        .LINE_BYTES_625(LP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .pix_valid(pix_valid),
        .pix_cb(pix_cb), .pix_y0(pix_y0), .pix_cr(pix_cr), .pix_y1(pix_y1),
        .pix_ready(pix_ready), .vid_data(vid_data), .vid_strobe(vid_strobe),
        .pix_underrun(pix_underrun)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s line=%0d byte=%0d actual=%0h expected=%0h",
                     tag, what, bline, bh, act, exp);
        end
    endtask

    function automatic bit v_of(input int line, input bit m);
        if (m) return (line >= 624) || (line <= 22) || (line >= 311 && line <= 335);
        return (line <= 9) || (line >= 264 && line <= 272);
    endfunction

    function automatic bit f_of(input int line, input bit m);
        if (m) return line >= 313;
        return (line <= 3) || (line >= 266);
    endfunction

    function automatic int flag_b(input int f, input int v, input int h);
        return 128 + 64*f + 32*v + 16*h + 8*((v+h)%2) + 4*((f+h)%2)
             + 2*((f+v)%2) + ((f+v+h)%2);
    endfunction

    function automatic int legal(input int b);
        return (b == 0) ? 1 : ((b == 255) ? 254 : b);
    endfunction

    function automatic bit cb_slot(input int line, input int h, input bit m);
        int hb;
        hb = (m ? LP : LN) - ACT;
        return !v_of(line, m) && h >= hb && ((h - hb) % 4 == 0);
    endfunction

    task automatic expect_byte(output int b, output string tag);
        int hb, f, v, k;
        hb = (bmode ? LP : LN) - ACT;
        f = f_of(bline, bmode);
        v = v_of(bline, bmode);
        if (bh < 4 || (bh >= hb - 4 && bh < hb)) begin
            k = (bh < 4) ? bh : bh - (hb - 4);
            if (k == 0) b = 255; else if (k < 3) b = 0; else b = flag_b(f, v, (bh < 4) ? 1 : 0);
            if (k == 3) tag = bmode ? "R4 R5 R7" : "R4 R6 R7";
            else if (bline == 1 && bh == 0) tag = "R3 R12";
            else tag = "R3";
        end else if (bh < hb || v != 0) begin
            b = (bh % 2 == 0) ? 8'h80 : 8'h10;
            tag = "R9";
        end else begin
            case ((bh - hb) % 4)
                0: b = ecb;
                1: b = ey0;
                2: b = ecr;
                default: b = ey1;
            endcase
            tag = (b == 0 || b == 255) ? "R10" : "R8";
            b = legal(b);
        end
    endtask

    task automatic drive_next();
        bit rdy;
        pix_valid = (dcnt % 5) != 2;
        pix_cb = 8'((dcnt * 29 + 7) & 255);
        pix_y0 = 8'((dcnt * 13) & 255);
        pix_cr = 8'((dcnt * 53 + 200) & 255);
        pix_y1 = 8'((dcnt * 101 + 255) & 255);
        if (dcnt % 97 == 0) begin
            pix_y0 = 8'h00;
            pix_cb = 8'hFF;
        end
        dcnt++;
        #1;
        rdy = cb_slot(bline, bh, bmode);
        check("R8", int'(pix_ready), int'(rdy), "pix_ready");
        exp_under = rdy && !pix_valid;
        if (rdy && pix_valid) begin
            ecb = pix_cb; ey0 = pix_y0; ecr = pix_cr; ey1 = pix_y1;
        end
    endtask

    task automatic advance();
        int len, nl;
        len = bmode ? LP : LN;
        nl  = bmode ? 625 : 525;
        if (bh == len - 1) begin
            bh = 0;
            if (bline == nl) begin
                bline = 1;
                bmode = pal_mode;
            end else begin
                bline++;
            end
        end else begin
            bh++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int eb;
        string tg;
        rst_n = 1'b0; pal_mode = 1'b0; pix_valid = 1'b0;
        pix_cb = 8'h00; pix_y0 = 8'h00; pix_cr = 8'h00; pix_y1 = 8'h00;
        dcnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", int'(vid_strobe), 0, "vid_strobe");
        check("R1", int'(vid_data), 0, "vid_data");
        check("R1", int'(pix_ready), 0, "pix_ready");
        check("R1", int'(pix_underrun), 0, "pix_underrun");

        rst_n = 1'b1;
        bline = 1; bh = 0; bmode = pal_mode;
        ecb = 8'h80; ey0 = 8'h10; ecr = 8'h80; ey1 = 8'h10;
        drive_next();
        for (int n = 0; n < RUN_BYTES; n++) begin
            @(posedge clk);
            @(negedge clk);
            expect_byte(eb, tg);
            check(tg, int'(vid_data), eb, "vid_data");
            check("R2", int'(vid_strobe), 1, "vid_strobe");
            check("R11", int'(pix_underrun), int'(exp_under), "pix_underrun");
            advance();
            // R12: switch standard mid-frame; takes effect at the next frame
            if (n == 10600) pal_mode = 1'b1;
            drive_next();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule